// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Controller

This block watches eight general-purpose input pins and raises a sticky flag for each pin on which the selected edge is seen. Each pin has four control bits: direction, pull enable, polarity and interrupt enable. The polarity bit does two jobs. It picks the active edge, rising or falling, and it picks which pull device the pad is asked to connect. Both effects apply only while the pin is an input.

Each pin is synchronised through a flop chain before its edges are detected. Software clears a flag by writing a one to that flag's bit. The block drives one registered interrupt request, which is the OR of every flag whose enable bit is set. A small register bus gives read and write access. Reads are combinational and writes take effect on the clock edge.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, all control registers and all flags read zero. The interrupt request is low, and both pull outputs are zero.
- R2: For an input pin, polarity 0 sets the pin's flag on a falling edge of its synchronised level, and polarity 1 sets it on a rising edge. The opposite edge leaves the flag unchanged.
- R3: While a pin's direction bit is 1 (output), no level change on that pin sets its flag.
- R4: pull_up_en_o[i] is 1 exactly when pull enable is 1, direction is 0 and polarity is 0. pull_dn_en_o[i] is 1 exactly when pull enable is 1, direction is 0 and polarity is 1. The two are never both 1.
- R5: Writing 1 to a bit of the flag register clears that flag, and writing 0 to a bit leaves it unchanged. When a clear and a detected edge land on the same clock, the flag ends up set.
- R6: irq_o is the registered OR over all pins of (flag AND enable). It is high in the cycle after the flag and enable that cause it.
- R7: Changing a polarity bit while the pin level is steady does not set a flag.
- R8: If a pin change is captured at clock edge k, the flag reads set after edge k+2 and not after edge k+1.
- R9: Register offsets are: direction 0x58, pull enable 0x59, synchronised pin level 0x5A (read-only), polarity 0x5B, interrupt enable 0x5D, flags 0x5F. When req_i=1 and we_i=0, rdata_o returns the addressed register in the same cycle. At any other time, and at any unmapped offset, it returns 0. A write to 0x5A or to an unmapped offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin levels |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pull_up_en_o | output | 8 | Per-pin pull-up request |
| pull_dn_en_o | output | 8 | Per-pin pull-down request |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives a flag clear on exactly the clock that an edge sets the same flag. A design that lets the clear win would lose that interrupt. It flips polarity while the pin is held steady at high and at low. A design that detects edges on the polarity-adjusted level would raise spurious flags there. It toggles pins while they are outputs, and a design that ignores the direction bit in detection would set flags. It also counts the flag latency edge by edge, which exposes a synchroniser with the wrong depth. A missing interrupt register shows up as an irq_o that is one cycle early.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned REG_AW = 8;
  localparam logic [REG_AW-1:0] OFF_DIR   = 8'h58;
  localparam logic [REG_AW-1:0] OFF_PULL  = 8'h59;
  localparam logic [REG_AW-1:0] OFF_LEVEL = 8'h5A;
  localparam logic [REG_AW-1:0] OFF_POL   = 8'h5B;
  localparam logic [REG_AW-1:0] OFF_IEN   = 8'h5D;
  localparam logic [REG_AW-1:0] OFF_FLAG  = 8'h5F;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] flag_i,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] pull_o,
  output logic [N_PINS-1:0] pol_o,
  output logic [N_PINS-1:0] ien_o,
  output logic [N_PINS-1:0] clr_o
);
  logic wr, rd;
  logic [N_PINS-1:0] dir_q, pull_q, pol_q, ien_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      pull_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
    end else if (wr) begin
      unique case (addr_i)
        OFF_DIR:  dir_q  <= wdata_i;
        OFF_PULL: pull_q <= wdata_i;
        OFF_POL:  pol_q  <= wdata_i;
        OFF_IEN:  ien_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr && addr_i == OFF_FLAG) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFF_DIR:   rdata_o = dir_q;
        OFF_PULL:  rdata_o = pull_q;
        OFF_LEVEL: rdata_o = lvl_i;
        OFF_POL:   rdata_o = pol_q;
        OFF_IEN:   rdata_o = ien_q;
        OFF_FLAG:  rdata_o = flag_i;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign pull_o = pull_q;
  assign pol_o  = pol_q;
  assign ien_o  = ien_q;

  AST_IDLE_BUS_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> rdata_o == '0); // R9
  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr) |-> ($stable(dir_q) && $stable(pol_q) && $stable(ien_q) && $stable(pull_q))); // R9
endmodule

// File: rtl/pin_irq_edge.sv
module pin_irq_edge #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] prev_i,
  input  logic [N_PINS-1:0] dir_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] flag_o
);
  logic [N_PINS-1:0] det, flag_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic rise, fall;
    assign rise   = lvl_i[i] & ~prev_i[i];
    assign fall   = ~lvl_i[i] & prev_i[i];
    // edge history uses raw level so a polarity flip cannot fake an edge
    assign det[i] = ~dir_i[i] & (pol_i[i] ? rise : fall);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= (flag_q[i] & ~clr_i[i]) | det[i];
    end

    AST_SET_NEEDS_LEVEL_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !$past(flag_q[i])) |-> $past(lvl_i[i] != prev_i[i])); // R7
    AST_SET_MATCHES_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !$past(flag_q[i])) |-> $past(pol_i[i] == lvl_i[i])); // R2
    AST_OUTPUT_PIN_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(dir_i[i]) && !$past(flag_q[i])) |-> !flag_q[i]); // R3
    AST_CLEAR_WITHOUT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(clr_i[i]) && !$past(det[i])) |-> !flag_q[i]); // R5
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(det[i]) |-> flag_q[i]); // R5
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_irq_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  output logic [N_PINS-1:0] pull_up_en_o,
  output logic [N_PINS-1:0] pull_dn_en_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] lvl, prev, dir, pull, pol, ien, clr, flag;
  logic irq_q;

  pin_irq_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i, .lvl_o(lvl), .prev_o(prev)
  );

  pin_irq_regs #(.N_PINS(N_PINS)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .lvl_i(lvl), .flag_i(flag),
    .dir_o(dir), .pull_o(pull), .pol_o(pol), .ien_o(ien), .clr_o(clr)
  );

  pin_irq_edge #(.N_PINS(N_PINS)) u_edge (
    .clk_i, .rst_ni, .lvl_i(lvl), .prev_i(prev),
    .dir_i(dir), .pol_i(pol), .clr_i(clr), .flag_o(flag)
  );

  assign pull_up_en_o = pull & ~dir & ~pol;
  assign pull_dn_en_o = pull & ~dir &  pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag & ien);
  end
  assign irq_o = irq_q;

  AST_IRQ_ONE_CYCLE_BEHIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(flag & ien))); // R6
  AST_PULLS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_en_o & pull_dn_en_o) == '0); // R4
  AST_NO_PULL_ON_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pull_up_en_o | pull_dn_en_o) & dir) == '0); // R4
endmodule

// File: tb/tb_pin_edge_irq.sv
`timescale 1ns/100ps
module tb_pin_edge_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = '0;
  logic       req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata, pu, pd;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_edge_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pull_up_en_o(pu), .pull_dn_en_o(pd), .irq_o(irq)
  );

  // behavioural reference model
  bit [7:0] m_dir, m_pe, m_pol, m_ien, m_flag;
  bit       m_irq;
  bit [7:0] hist[$] = '{8'h0, 8'h0, 8'h0};

  always @(posedge clk) begin
    bit [7:0] cur, old, set, clr, nflag;
    bit nirq;
    if (!rst_n) begin
      m_dir = 0; m_pe = 0; m_pol = 0; m_ien = 0; m_flag = 0; m_irq = 0;
      hist = '{8'h0, 8'h0, 8'h0};
    end else begin
      cur = hist[1]; old = hist[2]; set = 0;
      for (int i = 0; i < 8; i++) begin
        if (!m_dir[i]) begin
          if (m_pol[i] && cur[i] && !old[i]) set[i] = 1;
          if (!m_pol[i] && !cur[i] && old[i]) set[i] = 1;
        end
      end
      clr = (req && we && addr == 8'h5F) ? wdata : 8'h0;
      nirq = |(m_flag & m_ien);
      nflag = (m_flag & ~clr) | set;
      if (req && we) begin
        case (addr)
          8'h58: m_dir = wdata;
          8'h59: m_pe  = wdata;
          8'h5B: m_pol = wdata;
          8'h5D: m_ien = wdata;
          default: ;
        endcase
      end
      m_flag = nflag; m_irq = nirq;
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  function automatic bit [7:0] exp_rd();
    if (!(req && !we)) return 8'h0;
    case (addr)
      8'h58: return m_dir;
      8'h59: return m_pe;
      8'h5A: return hist[1];
      8'h5B: return m_pol;
      8'h5D: return m_ien;
      8'h5F: return m_flag;
      default: return 8'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison, just before the rising edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      chk("R4 pull_up", pu, m_pe & ~m_dir & ~m_pol);
      chk("R4 pull_dn", pd, m_pe & ~m_dir & m_pol);
      chk("R6 irq", {7'b0, irq}, {7'b0, m_irq});
      chk("R9 rdata", rdata, exp_rd());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 chk(tag, rdata, exp);
    req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk(8'h58, 8'h00, "R1 dir");
    rd_chk(8'h59, 8'h00, "R1 pull");
    rd_chk(8'h5B, 8'h00, "R1 pol");
    rd_chk(8'h5D, 8'h00, "R1 ien");
    rd_chk(8'h5F, 8'h00, "R1 flag");
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 pulls", pu | pd, 8'h00);

    // R2 edge polarity
    wr(8'h5B, 8'hF0);
    pin = 8'hFF; idle(4);
    rd_chk(8'h5F, 8'hF0, "R2 rising");
    pin = 8'h00; idle(4);
    rd_chk(8'h5F, 8'hFF, "R2 falling");

    // R5 write-one-to-clear
    wr(8'h5F, 8'h0F); rd_chk(8'h5F, 8'hF0, "R5 clear");
    wr(8'h5F, 8'h00); rd_chk(8'h5F, 8'hF0, "R5 zero write");
    wr(8'h5F, 8'hFF); rd_chk(8'h5F, 8'h00, "R5 clear all");

    // R6 masking
    wr(8'h5D, 8'h01);
    pin = 8'h02; idle(4);
    pin = 8'h00; idle(4);
    rd_chk(8'h5F, 8'h02, "R2 pin1 falling");
    chk("R6 masked", {7'b0, irq}, 8'h00);
    wr(8'h5D, 8'h02); idle(2);
    chk("R6 enabled", {7'b0, irq}, 8'h01);
    wr(8'h5F, 8'h02); idle(2);
    chk("R6 cleared", {7'b0, irq}, 8'h00);

    // R8 latency
    wr(8'h5D, 8'h10);
    @(negedge clk); pin = 8'h10; req = 1; we = 0; addr = 8'h5F;
    @(posedge clk); @(posedge clk); #1;
    chk("R8 not yet at k+1", rdata, 8'h00);
    @(posedge clk); #1;
    chk("R8 set at k+2", rdata, 8'h10);
    chk("R8 irq lags flag", {7'b0, irq}, 8'h00);
    @(posedge clk); #1;
    chk("R6 irq follows", {7'b0, irq}, 8'h01);
    @(negedge clk); req = 0;
    wr(8'h5F, 8'hFF);
    pin = 8'h00; idle(4);
    rd_chk(8'h5F, 8'h00, "R2 wrong edge ignored");
    wr(8'h5D, 8'h00);

    // R3 output pins, R4 pulls
    wr(8'h58, 8'hFF); wr(8'h59, 8'hFF); idle(1);
    chk("R4 output no pull", pu | pd, 8'h00);
    pin = 8'hFF; idle(4);
    pin = 8'h00; idle(4);
    rd_chk(8'h5F, 8'h00, "R3 output pins");
    wr(8'h58, 8'h00); idle(1);
    chk("R4 up", pu, 8'h0F);
    chk("R4 down", pd, 8'hF0);
    wr(8'h59, 8'h3C); idle(1);
    chk("R4 up partial", pu, 8'h0C);
    chk("R4 down partial", pd, 8'h30);

    // R7 polarity flips
    wr(8'h5B, 8'h0F); idle(4);
    rd_chk(8'h5F, 8'h00, "R7 flip at low");
    pin = 8'hFF; idle(4);
    rd_chk(8'h5F, 8'h0F, "R2 rising low nibble");
    wr(8'h5F, 8'hFF);
    wr(8'h5B, 8'hF0); idle(4);
    rd_chk(8'h5F, 8'h00, "R7 flip at high");

    // R5 clear coincident with edge
    @(negedge clk); pin = 8'hFE;
    @(negedge clk);
    @(negedge clk); req = 1; we = 1; addr = 8'h5F; wdata = 8'h01;
    @(negedge clk); req = 0; we = 0;
    rd_chk(8'h5F, 8'h01, "R5 edge wins");
    wr(8'h5F, 8'hFF);

    // R9 map
    pin = 8'hA5; idle(4);
    rd_chk(8'h5A, 8'hA5, "R9 level");
    wr(8'h5A, 8'h00);
    rd_chk(8'h5A, 8'hA5, "R9 level read-only");
    rd_chk(8'h5C, 8'h00, "R9 unmapped");

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
      if (lfsr[2:0] == 3'd0) pin = lfsr[15:8];
      req = lfsr[3];
      we = lfsr[4] & lfsr[5];
      case (lfsr[7:6])
        2'd0: addr = 8'h5F;
        2'd1: addr = 8'h5B;
        2'd2: addr = 8'h5D;
        default: addr = lfsr[9] ? 8'h58 : 8'h59;
      endcase
      wdata = lfsr[15:8] ^ lfsr[7:0];
    end
    @(negedge clk); req = 0; we = 0;
    idle(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule